// File: doc/BRIEF.md
# Timed Serial Loader Controller

This controller sits on the host side of a daisy chain of serial-in, latched-output high-voltage drivers. A frame holding one bit per channel of every device in the chain is handed over through a valid/ready handshake. The controller then produces the serial data line, the shift clock and the latch enable from a fast system clock. Every phase is stretched to the driver's minimum intervals, converted to whole system-clock cycles.

Once the last bit has been clocked in, the controller waits the required gap and issues exactly one latch pulse. It then returns to idle with a one-cycle completion pulse. Two configuration inputs, output blanking and output inversion, are registered and forwarded to the drivers without touching the load sequence. All nanosecond limits and the system clock frequency are parameters. Each cycle count is rounded up from its limit.

Top module: `serial_load_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, in_ready is 1, and ser_clk, ser_latch, ser_data and done are 0.
- R2: A frame is taken in the cycle where in_valid and in_ready are both 1. in_ready stays 0 from that cycle until the latch pulse has ended.
- R3: Each frame produces exactly FRAME_W rising edges of ser_clk. Bit i of frame_data holds channel (i mod CHAN_PER_DEV) of device (i / CHAN_PER_DEV), where device 0 is nearest the controller. Bits are sent from index FRAME_W-1 down to index 0, so the farthest device's highest channel goes first.
- R4: ser_clk stays high for at least 62 ns and low for at least 62 ns. Rising edges are at least 125 ns apart. At 100 MHz these are 7, 7 and 13 cycles.
- R5: ser_data is unchanged for at least 25 ns (3 cycles) before each rising ser_clk edge. It does not change in the cycle of that edge, which holds it for at least 10 ns afterwards.
- R6: ser_latch rises no sooner than 50 ns (5 cycles) after the last rising ser_clk edge. ser_clk is never high while ser_latch is high.
- R7: Each frame yields exactly one ser_latch pulse, at least 50 ns (5 cycles) wide.
- R8: ser_latch has been low for at least 50 ns (5 cycles) before any rising ser_clk edge, including the first edge of a frame accepted right after the previous one.
- R9: done is high for exactly one cycle per frame, in the first cycle after ser_latch falls, and in that same cycle in_ready returns to 1.
- R10: drv_blank and drv_pol follow cfg_blank and cfg_pol one cycle later, whether or not a load is in progress, and they leave the serial sequence unchanged.
- R11: in_valid and frame_data presented while in_ready is 0 are ignored. The bits sent are those of the accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Controller idle, frame can be taken |
| frame_data | input | FRAME_W | Channel bits, device-major, channel-minor |
| cfg_blank | input | 1 | Blanking setting |
| cfg_pol | input | 1 | Polarity setting |
| ser_data | output | 1 | Serial data to the first device |
| ser_clk | output | 1 | Shift clock |
| ser_latch | output | 1 | Latch enable |
| drv_blank | output | 1 | Registered blanking to the drivers |
| drv_pol | output | 1 | Registered polarity to the drivers |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sends several frames:
- All zeros and all ones. With these, ser_data never moves, so they expose a wrong clock count or wrong latch timing without any data effects.
- An alternating pattern. It makes ser_data change on every bit, which exercises the setup and hold windows at each edge.
- A single one at the top index and a single one at index 0. These pin down which end of the frame goes first.
- A pattern with the farthest device all ones and the near device all zeros. This tells device order apart from channel order.

Another frame has junk offered while the controller is busy. Two more frames go back to back to stress the gap between a latch pulse and the next rising clock. The configuration inputs are toggled mid-load.

// File: rtl/sl_pkg.sv
package sl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_GAP   = 3'd3,
    ST_LATCH = 3'd4
  } seq_st_e;

  // Round a nanosecond minimum up to whole system-clock cycles.
  function automatic int ns_to_cyc(input int ns, input int sys_mhz);
    return (ns * sys_mhz + 999) / 1000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sl_timer.sv
module sl_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         sdo,
  output logic         last
);

  localparam int RW = $clog2(W + 1);

  logic [W-1:0]  shreg_q, shreg_d;
  logic [RW-1:0] rem_q, rem_d;

  always_comb begin
    shreg_d = shreg_q;
    rem_d   = rem_q;
    if (load) begin
      shreg_d = din;
      rem_d   = RW'(W);
    end else if (shift) begin
      shreg_d = {shreg_q[W-2:0], 1'b0};
      rem_d   = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      rem_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      rem_q   <= rem_d;
    end
  end

  assign sdo  = shreg_q[W-1];
  assign last = (rem_q == RW'(1));

  // A shift is only requested while more than one bit remains.
  assert_no_overshift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (rem_q > RW'(1)));

endmodule

// File: rtl/sl_seq.sv
module sl_seq
  import sl_pkg::*;
#(
  parameter int HI  = 7,
  parameter int LO  = 7,
  parameter int GAP = 1,
  parameter int LW  = 5,
  parameter int TW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          expired,
  input  logic          last,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          sclk,
  output logic          le,
  output logic          done
);

  localparam logic [TW-1:0] HI_V  = TW'(HI - 1);
  localparam logic [TW-1:0] LO_V  = TW'(LO - 1);
  localparam logic [TW-1:0] GAP_V = TW'(GAP - 1);
  localparam logic [TW-1:0] LW_V  = TW'(LW - 1);

  seq_st_e st_q, st_d;
  logic    sclk_q, le_q, done_q, done_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (in_valid) begin
        st_d     = ST_LOW;
        sh_load  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = LO_V;
      end
      ST_LOW: if (expired) begin
        st_d     = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = HI_V;
      end
      ST_HIGH: if (expired) begin
        tmr_load = 1'b1;
        if (last) begin
          st_d    = ST_GAP;
          tmr_val = GAP_V;
        end else begin
          st_d     = ST_LOW;
          sh_shift = 1'b1;
          tmr_val  = LO_V;
        end
      end
      ST_GAP: if (expired) begin
        st_d     = ST_LATCH;
        tmr_load = 1'b1;
        tmr_val  = LW_V;
      end
      ST_LATCH: if (expired) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sclk_q <= (st_d == ST_HIGH);
      le_q   <= (st_d == ST_LATCH);
      done_q <= done_d;
    end
  end

  assign in_ready = (st_q == ST_IDLE);
  assign sclk     = sclk_q;
  assign le       = le_q;
  assign done     = done_q;

  // Run-length counters for width checks.
  logic [15:0] hi_run, lo_run, le_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
      le_run <= '0;
    end else begin
      hi_run <= sclk_q ? ((hi_run == '1) ? hi_run : hi_run + 1'b1) : '0;
      lo_run <= !sclk_q ? ((lo_run == '1) ? lo_run : lo_run + 1'b1) : '0;
      le_run <= le_q ? ((le_run == '1) ? le_run : le_run + 1'b1) : '0;
    end
  end

  assert_sclk_high_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> (hi_run >= 16'(HI)));

  assert_sclk_low_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> (lo_run >= 16'(LO)));

  assert_clk_latch_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_q && le_q));

  assert_latch_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le_q) |-> (le_run >= 16'(LW)));

  assert_done_after_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le_q) |-> (done_q && in_ready));

endmodule

// File: rtl/serial_load_ctrl.sv
module serial_load_ctrl
  import sl_pkg::*;
#(
  parameter int CHAN_PER_DEV = 32,
  parameter int NUM_DEV      = 2,
  parameter int SYS_MHZ      = 100,
  parameter int T_HI_NS      = 62,
  parameter int T_LO_NS      = 62,
  parameter int T_PER_NS     = 125,
  parameter int T_SU_NS      = 25,
  parameter int T_HD_NS      = 10,
  parameter int T_LED_NS     = 50,
  parameter int T_LEW_NS     = 50,
  parameter int T_LESU_NS    = 50,
  localparam int FRAME_W     = CHAN_PER_DEV * NUM_DEV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               cfg_blank,
  input  logic               cfg_pol,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               ser_latch,
  output logic               drv_blank,
  output logic               drv_pol,
  output logic               done
);

  localparam int HI_C  = imax(1, imax(ns_to_cyc(T_HI_NS, SYS_MHZ), ns_to_cyc(T_HD_NS, SYS_MHZ)));
  localparam int LO_A  = imax(ns_to_cyc(T_LO_NS, SYS_MHZ), ns_to_cyc(T_SU_NS, SYS_MHZ));
  localparam int LO_B  = imax(ns_to_cyc(T_LESU_NS, SYS_MHZ), ns_to_cyc(T_PER_NS, SYS_MHZ) - HI_C);
  localparam int LO_C  = imax(1, imax(LO_A, LO_B));
  localparam int GAP_C = imax(1, ns_to_cyc(T_LED_NS, SYS_MHZ) - HI_C);
  localparam int LW_C  = imax(1, ns_to_cyc(T_LEW_NS, SYS_MHZ));
  localparam int MAX_C = imax(imax(HI_C, LO_C), imax(GAP_C, LW_C));
  localparam int TW    = imax(1, $clog2(MAX_C + 1));

  logic          tmr_load, expired, sh_load, sh_shift, last;
  logic [TW-1:0] tmr_val;
  logic          blank_q, pol_q;

  sl_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sl_shifter #(.W(FRAME_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .shift (sh_shift),
    .din   (frame_data),
    .sdo   (ser_data),
    .last  (last)
  );

  sl_seq #(.HI(HI_C), .LO(LO_C), .GAP(GAP_C), .LW(LW_C), .TW(TW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .expired  (expired),
    .last     (last),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .sh_load  (sh_load),
    .sh_shift (sh_shift),
    .sclk     (ser_clk),
    .le       (ser_latch),
    .done     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= 1'b0;
      pol_q   <= 1'b0;
    end else begin
      blank_q <= cfg_blank;
      pol_q   <= cfg_pol;
    end
  end

  assign drv_blank = blank_q;
  assign drv_pol   = pol_q;

  // Latch only rises while the controller still holds off new frames.
  assert_busy_during_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_latch) |-> !in_ready);

endmodule

// File: tb/serial_load_ctrl_tb.sv
module serial_load_ctrl_tb;

  localparam int CH = 32;
  localparam int ND = 2;
  localparam int FW = CH * ND;
  localparam int PER_NS = 10;
  localparam int HI_MIN   = (62 + PER_NS - 1) / PER_NS;
  localparam int LO_MIN   = (62 + PER_NS - 1) / PER_NS;
  localparam int PRD_MIN  = (125 + PER_NS - 1) / PER_NS;
  localparam int SU_MIN   = (25 + PER_NS - 1) / PER_NS;
  localparam int HD_MIN   = 1;
  localparam int LED_MIN  = (50 + PER_NS - 1) / PER_NS;
  localparam int LEW_MIN  = (50 + PER_NS - 1) / PER_NS;
  localparam int LESU_MIN = (50 + PER_NS - 1) / PER_NS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, in_valid, in_ready, cfg_blank, cfg_pol;
  logic [FW-1:0] frame_data;
  logic          ser_data, ser_clk, ser_latch, drv_blank, drv_pol, done;

  serial_load_ctrl #(.CHAN_PER_DEV(CH), .NUM_DEV(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .frame_data(frame_data), .cfg_blank(cfg_blank), .cfg_pol(cfg_pol),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch),
    .drv_blank(drv_blank), .drv_pol(drv_pol), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int frames = 0;
  int le_pulses = 0;
  int done_cnt = 0;
  bit exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: samples on the falling edge.
  logic p_sclk = 1'b0, p_le = 1'b0, p_sdo = 1'b0;
  int hi_len = 0, lo_len = 1000, le_len = 0, stab = 1000;
  int since_rise = 1000, since_lfall = 1000;

  always @(negedge clk) begin
    if (rst_n) begin
      if (since_rise < 100000) since_rise++;
      if (since_lfall < 100000) since_lfall++;
      if (ser_clk && !p_sclk) begin
        chk(lo_len >= LO_MIN, "R4", "low phase", lo_len, LO_MIN);
        chk(since_rise >= PRD_MIN, "R4", "edge spacing", since_rise, PRD_MIN);
        chk(ser_data == p_sdo && stab >= SU_MIN, "R5", "setup", stab, SU_MIN);
        chk(!ser_latch && since_lfall >= LESU_MIN, "R8", "latch low before clock",
            since_lfall, LESU_MIN);
        if (exp_q.size() == 0) chk(1'b0, "R3", "extra clock edge", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk(ser_data == e, "R3", "serial bit", ser_data, e);
        end
      end
      if (ser_data != p_sdo)
        chk(since_rise >= HD_MIN, "R5", "hold", since_rise, HD_MIN);
      if (!ser_clk && p_sclk)
        chk(hi_len >= HI_MIN, "R4", "high phase", hi_len, HI_MIN);
      if (ser_latch && !p_le) begin
        le_pulses++;
        chk(since_rise >= LED_MIN, "R6", "latch after last edge", since_rise, LED_MIN);
        chk(!ser_clk, "R6", "clock low at latch", ser_clk, 0);
        chk(exp_q.size() == 0, "R3", "bits left at latch", exp_q.size(), 0);
        chk(!in_ready, "R2", "ready during latch", in_ready, 0);
      end
      if (!ser_latch && p_le)
        chk(le_len >= LEW_MIN, "R7", "latch width", le_len, LEW_MIN);
      if (done) begin
        done_cnt++;
        chk(p_le && !ser_latch && in_ready, "R9", "done placement",
            {p_le, ser_latch, in_ready}, 3'b101);
      end
      if (ser_clk) begin hi_len++; lo_len = 0; end
      else begin lo_len++; hi_len = 0; end
      if (ser_latch) le_len++; else le_len = 0;
      if (ser_data == p_sdo) stab++; else stab = 1;
      if (ser_clk && !p_sclk) since_rise = 0;
      if (!ser_latch && p_le) since_lfall = 0;
      p_sclk = ser_clk;
      p_le   = ser_latch;
      p_sdo  = ser_data;
    end
  end

  // Driver: pushes expected bits, highest index first.
  task automatic send_frame(input logic [FW-1:0] d, input bit junk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid   = 1'b1;
    frame_data = d;
    for (int i = FW - 1; i >= 0; i--) exp_q.push_back(d[i]);
    @(negedge clk);
    in_valid = 1'b0;
    frames++;
    chk(!in_ready, "R2", "ready after accept", in_ready, 0);
    if (junk) begin
      in_valid   = 1'b1;
      frame_data = ~d;
      repeat (40) @(negedge clk);
      chk(!in_ready, "R11", "busy while junk offered", in_ready, 0);
      in_valid = 1'b0;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; frame_data = '0;
    cfg_blank = 1'b0; cfg_pol = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready && !ser_clk && !ser_latch && !done && !ser_data, "R1", "reset state",
        {in_ready, ser_clk, ser_latch, done, ser_data}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !ser_clk && !ser_latch && !done, "R1", "after release",
        {in_ready, ser_clk, ser_latch, done}, 4'b1000);

    send_frame('0, 1'b0);                      wait_idle();
    send_frame('1, 1'b0);                      wait_idle();
    send_frame({(FW/2){2'b10}}, 1'b0);         wait_idle();
    send_frame(FW'(1) << (FW - 1), 1'b0);      wait_idle();
    send_frame(FW'(1), 1'b0);                  wait_idle();
    send_frame({{CH{1'b1}}, {CH{1'b0}}}, 1'b0); wait_idle();
    // R11: junk offered while busy
    send_frame(64'h0123_4567_89AB_CDEF, 1'b1); wait_idle();

    // R10: configuration follows one cycle later, also mid-load
    cfg_blank = 1'b1;
    @(negedge clk);
    chk(drv_blank == 1'b1, "R10", "blank follows", drv_blank, 1);
    send_frame(64'hF0F0_0F0F_3C3C_C3C3, 1'b0);
    repeat (100) @(negedge clk);
    cfg_pol = 1'b1; cfg_blank = 1'b0;
    @(negedge clk);
    chk(drv_pol == 1'b1 && drv_blank == 1'b0, "R10", "config mid-load",
        {drv_pol, drv_blank}, 2'b10);
    wait_idle();

    // R8: back-to-back frames
    send_frame(64'hDEAD_BEEF_5555_AAAA, 1'b0);
    send_frame(64'h8000_0001_7FFF_FFFE, 1'b0);
    wait_idle();

    chk(le_pulses == frames, "R7", "latch pulses per frame", le_pulses, frames);
    chk(done_cnt == frames, "R9", "done pulses per frame", done_cnt, frames);
    chk(exp_q.size() == 0, "R3", "bits unsent", exp_q.size(), 0);
    finish_run();
  end

endmodule